// File: doc/BRIEF.md
# Latched Event Time Stamp Counter

The block keeps a wide running event time stamp in the system clock domain. The count moves forward by one on each time-stamp tick. A tick comes from one of two sources. The first is an internal divider that turns the system clock into a nominal 10 MHz pulse. The second is an external time-stamp clock, which is first brought into the system domain and edge-detected. An inhibit input vetoes ticks. The vetoed tick also leaves the block as a one-cycle pulse, so that other time-stamp modules can follow the same count.

An event trigger drives the capture input. On its synchronised rising edge, the running count is copied into a holding register and a valid flag is raised. The readout fetches the held value and acknowledges it. If a second capture arrives before that acknowledge, the held value is kept and an overrun flag is raised. The count can be zeroed in two ways: a synchronised hardware clear line, or a software clear strobe that is already in the system domain.

Top module: `tstamp_latch_top`

## Requirements
- R1: While reset is asserted and straight after it, stamp_o, stamp_valid_o, overrun_o and tick_o are all 0, and the running count is 0.
- R2: With ext_sel_i = 0 and inhibit_i = 0, the running count advances exactly once every TICK_DIV system clocks. tick_o is high for one cycle per advance, in the cycle after the advance, so any window of 5·TICK_DIV cycles holds exactly 5 pulses.
- R3: With ext_sel_i = 1, each rising edge of ext_clk_i advances the count once, three clocks after the edge is sampled (two synchroniser flops plus an edge register). The internal divider then has no effect.
- R4: While inhibit_i = 1, the count does not advance and tick_o stays 0 in the following cycle.
- R5: A rising edge of latch_i is synchronised the same way as ext_clk_i. It copies the count into stamp_o and sets stamp_valid_o. The value copied is the count before any advance or clear in that same cycle.
- R6: A capture while stamp_valid_o = 1 and rd_ack_i = 0 leaves stamp_o unchanged and sets overrun_o.
- R7: rd_ack_i = 1 clears stamp_valid_o and overrun_o. A capture in the same cycle as the acknowledge is stored as a fresh value: valid is 1 and overrun is 0.
- R8: sw_clear_i = 1, or hw_clear_i after two synchroniser flops, zeroes the count. A clear wins over an advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_sel_i | input | 1 | 1 selects the external time-stamp clock, 0 selects the internal divider |
| ext_clk_i | input | 1 | External time-stamp clock, asynchronous |
| inhibit_i | input | 1 | Tick veto, system domain |
| latch_i | input | 1 | Capture request from the event trigger, asynchronous |
| hw_clear_i | input | 1 | Hardware clear, asynchronous level |
| sw_clear_i | input | 1 | Software clear strobe, system domain |
| rd_ack_i | input | 1 | Readout acknowledge of the held value |
| tick_o | output | 1 | Vetoed time-stamp tick, one cycle wide |
| stamp_o | output | CNT_W | Held time stamp |
| stamp_valid_o | output | 1 | Held value not yet acknowledged |
| overrun_o | output | 1 | A capture was lost while the held value was pending |

## Verification
The internal divider is tried over whole windows of free running. Here the pulse count separates a correct period from an off-by-one divider. The external clock is tried as a slow square wave. This shows that only its edges count and that the divider is ignored. Inhibit windows and held clears with ticks present show whether the veto and the clear priority act at the right point. Capture pulses are placed against pending values, acknowledges and clears, including an acknowledge in the same cycle as a capture. A behavioural model compared every cycle pins down the exact capture cycle and the pre-advance value.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;

  typedef enum logic {
    TS_SRC_INT = 1'b0,
    TS_SRC_EXT = 1'b1
  } ts_src_e;

  // Pick the tick source, then apply the veto.
  function automatic logic ts_tick_pick(input ts_src_e src, input logic ext_rise,
                                        input logic int_tick, input logic veto);
    logic raw;
    raw = (src == TS_SRC_EXT) ? ext_rise : int_tick;
    return raw & ~veto;
  endfunction

  // Next overrun flag: an acknowledge clears it; a capture against a pending value sets it.
  function automatic logic ts_overrun_next(input logic ovr, input logic cap,
                                           input logic pending, input logic ack);
    return ack ? 1'b0 : (ovr | (cap & pending));
  endfunction

endpackage

// File: rtl/tstamp_sync.sv
module tstamp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

  initial assert (STAGES >= 2) else $error("tstamp_sync needs at least two stages");
endmodule

// File: rtl/tstamp_tick_gen.sv
module tstamp_tick_gen #(
  parameter int DIV = 5
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                    phase <= phase + 1'b1;
  end

  assign tick_o = (phase == LAST);

  // R2: a tick is never followed directly by another one
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/tstamp_counter.sv
module tstamp_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);
  function automatic logic [CNT_W-1:0] count_next(input logic [CNT_W-1:0] cur,
                                                  input logic clr, input logic inc);
    if (clr)      return '0;
    else if (inc) return cur + 1'b1;
    else          return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_o <= '0;
    else        count_o <= count_next(count_o, clr_i, inc_i);
  end

  // R8: a clear zeroes the count even when a tick is present
  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> count_o == '0);
  // R4: no tick means no movement
  assert_hold_without_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !inc_i) |=> $stable(count_o));
endmodule

// File: rtl/tstamp_capture.sv
module tstamp_capture #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic             cap_i,
  input  logic             ack_i,
  output logic [CNT_W-1:0] stamp_o,
  output logic             valid_o,
  output logic             overrun_o
);
  import tstamp_pkg::*;

  logic take;
  assign take = cap_i & (~valid_o | ack_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stamp_o   <= '0;
      valid_o   <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      if (take) stamp_o <= count_i;
      if (cap_i)      valid_o <= 1'b1;
      else if (ack_i) valid_o <= 1'b0;
      overrun_o <= ts_overrun_next(overrun_o, cap_i, valid_o, ack_i);
    end
  end

  // R6: a capture against a pending value keeps it and flags overrun
  assert_keep_on_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_i && valid_o && !ack_i) |=> ($stable(stamp_o) && overrun_o));
  // R7: acknowledge without capture empties the holding register flags
  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !cap_i) |=> (!valid_o && !overrun_o));
  // R5: a capture always leaves a valid value
  assert_capture_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> valid_o);
endmodule

// File: rtl/tstamp_latch_top.sv
module tstamp_latch_top #(
  parameter int CNT_W       = 64,
  parameter int TICK_DIV    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_sel_i,
  input  logic             ext_clk_i,
  input  logic             inhibit_i,
  input  logic             latch_i,
  input  logic             hw_clear_i,
  input  logic             sw_clear_i,
  input  logic             rd_ack_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] stamp_o,
  output logic             stamp_valid_o,
  output logic             overrun_o
);
  import tstamp_pkg::*;

  localparam int N_ASYNC = 3;
  localparam int IX_EXT  = 0;
  localparam int IX_LAT  = 1;
  localparam int IX_CLR  = 2;

  logic [N_ASYNC-1:0] async_in;
  logic [N_ASYNC-1:0] synced;
  assign async_in = {hw_clear_i, latch_i, ext_clk_i};

  for (genvar g = 0; g < N_ASYNC; g++) begin : g_sync
    tstamp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(async_in[g]), .dout(synced[g]));
  end

  // Edge registers for the two inputs used as events
  logic ext_prev, lat_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_prev <= 1'b0;
      lat_prev <= 1'b0;
    end else begin
      ext_prev <= synced[IX_EXT];
      lat_prev <= synced[IX_LAT];
    end
  end

  // Named internal events
  logic ext_rise, cap_evt, int_tick, tick_en, clr_evt;
  assign ext_rise = synced[IX_EXT] & ~ext_prev;
  assign cap_evt  = synced[IX_LAT] & ~lat_prev;
  assign clr_evt  = synced[IX_CLR] | sw_clear_i;

  tstamp_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(int_tick));

  assign tick_en = ts_tick_pick(ts_src_e'(ext_sel_i), ext_rise, int_tick, inhibit_i);

  logic [CNT_W-1:0] count;
  tstamp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_evt), .inc_i(tick_en), .count_o(count));

  tstamp_capture #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .count_i(count), .cap_i(cap_evt), .ack_i(rd_ack_i),
    .stamp_o(stamp_o), .valid_o(stamp_valid_o), .overrun_o(overrun_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_o <= 1'b0;
    else        tick_o <= tick_en;
  end

  // R4: vetoed cycles never show a tick on the output
  assert_inhibit_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit_i |=> !tick_o);
  // R3: in external mode no tick leaves without an external edge
  assert_ext_only_edges_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sel_i && !ext_rise) |=> !tick_o);
  // R5: the held value is the count before this cycle's change
  assert_capture_pre_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && !stamp_valid_o) |=> stamp_o == $past(count));
endmodule

// File: tb/tstamp_latch_top_tb.sv
module tstamp_latch_top_tb;
  localparam int W   = 64;
  localparam int DIV = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_sel_i = 0, ext_clk_i = 0, inhibit_i = 0, latch_i = 0;
  logic hw_clear_i = 0, sw_clear_i = 0, rd_ack_i = 0;
  logic tick_o, stamp_valid_o, overrun_o;
  logic [W-1:0] stamp_o;

  always #10 clk = ~clk;

  tstamp_latch_top #(.CNT_W(W), .TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_sel_i(ext_sel_i), .ext_clk_i(ext_clk_i),
    .inhibit_i(inhibit_i), .latch_i(latch_i), .hw_clear_i(hw_clear_i),
    .sw_clear_i(sw_clear_i), .rd_ack_i(rd_ack_i), .tick_o(tick_o),
    .stamp_o(stamp_o), .stamp_valid_o(stamp_valid_o), .overrun_o(overrun_o));

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference: histories of the sampled async inputs and plain integers
  bit e_h[3], l_h[3], c_h[2];
  int unsigned phase;
  longint unsigned m_count, m_stamp;
  bit m_valid, m_ovr, m_tick;

  always @(posedge clk) begin
    if (!rst_n) begin
      e_h = '{0, 0, 0}; l_h = '{0, 0, 0}; c_h = '{0, 0};
      phase = 0; m_count = 0; m_stamp = 0; m_valid = 0; m_ovr = 0; m_tick = 0;
    end else begin
      bit erise, lrise, clr, itick, tk;
      erise = e_h[1] && !e_h[2];
      lrise = l_h[1] && !l_h[2];
      clr   = c_h[1] || sw_clear_i;
      itick = (phase == DIV - 1);
      tk    = (ext_sel_i ? erise : itick) && !inhibit_i;
      if (lrise && (!m_valid || rd_ack_i)) m_stamp = m_count;
      if (rd_ack_i) m_ovr = 0;
      else if (lrise && m_valid) m_ovr = 1;
      if (lrise) m_valid = 1;
      else if (rd_ack_i) m_valid = 0;
      if (clr) m_count = 0;
      else if (tk) m_count = m_count + 1;
      m_tick = tk;
      phase = itick ? 0 : phase + 1;
      e_h[2] = e_h[1]; e_h[1] = e_h[0]; e_h[0] = ext_clk_i;
      l_h[2] = l_h[1]; l_h[1] = l_h[0]; l_h[0] = latch_i;
      c_h[1] = c_h[0]; c_h[0] = hw_clear_i;
    end
  end

  // Every-cycle comparison and tick pulse counting
  int tick_seen = 0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(stamp_o == m_stamp, "R5", "stamp", stamp_o, m_stamp);
      check(stamp_valid_o == m_valid, "R7", "valid", stamp_valid_o, m_valid);
      check(overrun_o == m_ovr, "R6", "overrun", overrun_o, m_ovr);
      check(tick_o == m_tick, "R2", "tick", tick_o, m_tick);
      if (tick_o) tick_seen++;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_latch();
    latch_i = 1; step(2); latch_i = 0; step(1);
  endtask

  task automatic ack();
    rd_ack_i = 1; step(1); rd_ack_i = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    longint unsigned held;
    step(3);
    // R1: reset state
    check(stamp_o == 0 && !stamp_valid_o && !overrun_o && !tick_o, "R1", "reset outputs",
          {stamp_o[61:0], stamp_valid_o, tick_o}, 0);
    rst_n = 1;
    step(1);
    check(stamp_o == 0 && !stamp_valid_o, "R1", "after release", stamp_o, 0);

    // R2: internal divider rate
    step(7);
    tick_seen = 0; step(5 * DIV * 10);
    check(tick_seen == 50, "R2", "internal ticks in window", tick_seen, 50);

    // R5: capture
    pulse_latch(); step(2);
    check(stamp_valid_o == 1, "R5", "valid after capture", stamp_valid_o, 1);
    check(stamp_o == m_stamp && stamp_o > 0, "R5", "captured value", stamp_o, m_stamp);
    held = stamp_o;

    // R6: second capture before acknowledge
    step(9); pulse_latch(); step(2);
    check(overrun_o == 1, "R6", "overrun set", overrun_o, 1);
    check(stamp_o == held, "R6", "held value kept", stamp_o, held);

    // R7: acknowledge clears, then capture coincident with acknowledge
    ack(); step(1);
    check(!stamp_valid_o && !overrun_o, "R7", "ack clears flags",
          {stamp_valid_o, overrun_o}, 0);
    pulse_latch(); step(3);
    latch_i = 1; step(2); rd_ack_i = 1; step(1); rd_ack_i = 0; latch_i = 0; step(1);
    check(stamp_valid_o && !overrun_o, "R7", "ack with capture is fresh",
          {stamp_valid_o, overrun_o}, 2);
    check(stamp_o == m_stamp && stamp_o != held, "R7", "fresh value", stamp_o, m_stamp);
    ack();

    // R4: inhibit window
    inhibit_i = 1; step(1);
    tick_seen = 0; step(60);
    check(tick_seen == 0, "R4", "ticks while inhibited", tick_seen, 0);
    pulse_latch(); step(2); held = stamp_o; ack();
    step(20); pulse_latch(); step(2);
    check(stamp_o == held, "R4", "count frozen", stamp_o, held);
    ack();

    // R8: software clear held while ticks run, capture during clear gives zero
    inhibit_i = 0; sw_clear_i = 1; step(12);
    pulse_latch(); step(2);
    check(stamp_o == 0, "R8", "clear beats tick", stamp_o, 0);
    sw_clear_i = 0; ack();

    // R3: external clock, 6 rising edges
    step(20); ext_sel_i = 1; step(4);
    tick_seen = 0;
    for (int i = 0; i < 6; i++) begin
      ext_clk_i = 1; step(4); ext_clk_i = 0; step(4);
    end
    step(6);
    check(tick_seen == 6, "R3", "external edges counted", tick_seen, 6);
    pulse_latch(); step(2);
    check(stamp_o == m_stamp, "R3", "external count captured", stamp_o, m_stamp);
    ack();

    // R8: hardware clear in external mode with inhibit so the count stays put
    inhibit_i = 1; hw_clear_i = 1; step(1); hw_clear_i = 0; step(4);
    pulse_latch(); step(2);
    check(stamp_o == 0, "R8", "hardware clear", stamp_o, 0);
    ack(); inhibit_i = 0; step(5);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
    end
  end
endmodule